// File: doc/BRIEF.md
# Two-Point Modulation Digital PLL Core

This block is the digital core of a phase-locked loop that runs on the reference clock. On every reference edge it advances a reference phase by a channel frequency word plus the current modulation sample. It also keeps a running count of oscillator cycles that arrives as a per-period increment. The difference between reference phase and oscillator count is the coarse phase error. A fractional correction from a time-to-digital converter is added to it. The result passes through a one-pole smoothing stage and a proportional/integral filter. The period-to-period change of the filter output is the frequency correction.

The modulation sample is used in two places: inside the reference phase sum, and again added straight to the frequency correction. The sum is then scaled by an estimated reciprocal oscillator gain to give a registered tuning word with a valid flag. Because the direct path reaches the output one edge after the sample, wideband modulation is not limited by the loop bandwidth, and the loop only removes slow errors.

Top module: `tpm_dpll_core`

## Requirements
- R1: A synchronous active-high reset clears the reference phase, the oscillator counter, the smoothing state, the integral state, the stored previous filter output and the tuning word, and drops the valid flag.
- R2: All phases are signed 24-bit fixed point with 8 fractional bits. At each non-reset edge the reference phase advances by `fcw_i + fmod_i`, wrapping modulo 2^24.
- R3: The oscillator counter is 16 bits wide. It advances by the unsigned 8-bit `osc_inc_i` at each non-reset edge and wraps modulo 2^16. The coarse error is the reference phase minus 256 times the counter, taken modulo 2^24, so a counter wrap leaves a locked loop undisturbed.
- R4: The phase error is the coarse error plus `tdc_frac_i`, an unsigned 8-bit fraction with LSB 2^-8 of a cycle, and it uses the input present in the same cycle.
- R5: At each edge the smoothed error becomes `s + ((e - s) >>> pole_sh_i)`. With `pole_sh_i = 0` it equals the previous cycle's phase error.
- R6: The filter output is `(s >>> kp_sh_i) + I`, where `s` is the smoothed error and `I` is the integral state. At each edge `I` gains `s >>> ki_sh_i`. All shifts are arithmetic.
- R7: The frequency correction is the filter output minus the filter output stored at the previous edge.
- R8: At each edge the tuning word becomes `((corr + fmod_i) * gain_inv_i) >>> 11`, truncated to 24 bits. `gain_inv_i` is unsigned with 2048 meaning unity. A modulation step therefore reaches the tuning word one edge after it is applied.
- R9: The valid flag rises at the first edge after reset is released and stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| fcw_i | input | 24 | Channel frequency word, signed Q16.8 cycles per period |
| fmod_i | input | 24 | Modulation sample, signed Q16.8 |
| osc_inc_i | input | 8 | Oscillator cycles counted in this reference period |
| tdc_frac_i | input | 8 | Normalized fractional phase error, unsigned Q0.8 |
| pole_sh_i | input | 4 | Smoothing pole shift |
| kp_sh_i | input | 4 | Proportional gain shift |
| ki_sh_i | input | 4 | Integral gain shift |
| gain_inv_i | input | 12 | Estimated reciprocal oscillator gain, 2048 = 1.0 |
| tw_o | output | 24 | Registered oscillator tuning word |
| tw_vld_o | output | 1 | Tuning word valid |

## Verification
The direct modulation path and the loop correction both feed the same tuning word in the same cycle. A modulation step applied while the loop is locked shows this most clearly. The first tuning word after the step must equal the scaled sample alone, because the loop has not yet seen a phase error. Every later word must equal the scaled sum of the sample and the loop's own correction. A second coincidence, an oscillator-counter wrap during locked operation, is provoked with a large per-period increment, and the check is that the tuning word stays at zero across the wrap.

// File: rtl/tpm_pkg.sv
package tpm_pkg;
    localparam int PH_W     = 24;
    localparam int FRAC_W   = 8;
    localparam int CNT_W    = PH_W - FRAC_W;
    localparam int INC_W    = 8;
    localparam int SH_W     = 4;
    localparam int G_W      = 12;
    localparam int G_ONE_SH = G_W - 1;
    localparam int PROD_W   = PH_W + G_W + 1;

    typedef logic signed [PH_W-1:0] phase_t;

    typedef struct packed {
        logic [SH_W-1:0] pole_sh;
        logic [SH_W-1:0] kp_sh;
        logic [SH_W-1:0] ki_sh;
    } lf_cfg_t;

    function automatic phase_t cycles_to_phase(input logic [CNT_W-1:0] c);
        return phase_t'({c, {FRAC_W{1'b0}}});
    endfunction

    function automatic phase_t frac_to_phase(input logic [FRAC_W-1:0] f);
        return phase_t'({{CNT_W{1'b0}}, f});
    endfunction

    function automatic phase_t inc_to_phase(input logic [INC_W-1:0] n);
        return cycles_to_phase(CNT_W'(n));
    endfunction
endpackage

// File: rtl/tpm_phase_detect.sv
module tpm_phase_detect
    import tpm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  phase_t           fcw,
    input  phase_t           fmod,
    input  logic [INC_W-1:0] osc_inc,
    input  logic [FRAC_W-1:0] tdc_frac,
    output phase_t           pe
);
    phase_t           ref_q;
    logic [CNT_W-1:0] cnt_q;
    logic             upd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q <= '0;
            cnt_q <= '0;
            upd_q <= 1'b0;
        end else begin
            ref_q <= ref_q + fcw + fmod;
            cnt_q <= cnt_q + CNT_W'(osc_inc);
            upd_q <= 1'b1;
        end
    end

    always_comb begin
        pe = ref_q - cycles_to_phase(cnt_q) + frac_to_phase(tdc_frac);
    end

    // R3
    pe_step_chk: assert property (@(posedge clk) disable iff (rst)
        upd_q |-> phase_t'(pe - $past(pe)) ==
            phase_t'($past(fcw) + $past(fmod) - inc_to_phase($past(osc_inc))
                     + frac_to_phase(tdc_frac) - frac_to_phase($past(tdc_frac))));
endmodule

// File: rtl/tpm_loop_filter.sv
module tpm_loop_filter
    import tpm_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  phase_t  pe,
    input  lf_cfg_t cfg,
    output phase_t  corr
);
    phase_t smooth_q;
    phase_t integ_q;
    phase_t lf_prev_q;
    phase_t lf;
    logic   upd_q;

    always_comb begin
        lf   = (smooth_q >>> cfg.kp_sh) + integ_q;
        corr = lf - lf_prev_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            smooth_q  <= '0;
            integ_q   <= '0;
            lf_prev_q <= '0;
            upd_q     <= 1'b0;
        end else begin
            smooth_q  <= smooth_q + ((pe - smooth_q) >>> cfg.pole_sh);
            integ_q   <= integ_q + (smooth_q >>> cfg.ki_sh);
            lf_prev_q <= lf;
            upd_q     <= 1'b1;
        end
    end

    // R5
    pole_bypass_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_q && $past(cfg.pole_sh) == '0) |-> smooth_q == $past(pe));
endmodule

// File: rtl/tpm_dco_norm.sv
module tpm_dco_norm
    import tpm_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  phase_t         corr,
    input  phase_t         fmod,
    input  logic [G_W-1:0] gain_inv,
    output phase_t         tw,
    output logic           vld
);
    phase_t                    sum;
    logic signed [PROD_W-1:0]  prod;

    always_comb begin
        sum  = corr + fmod;
        prod = sum * $signed({1'b0, gain_inv});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tw  <= '0;
            vld <= 1'b0;
        end else begin
            tw  <= prod[G_ONE_SH +: PH_W];
            vld <= 1'b1;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !vld |-> tw == '0);
    // R9
    vld_hold_chk: assert property (@(posedge clk) disable iff (rst)
        vld |=> vld);
    // R8
    unity_gain_chk: assert property (@(posedge clk) disable iff (rst)
        (vld && $past(gain_inv) == G_W'(1 << G_ONE_SH)) |-> tw == $past(sum));
endmodule

// File: rtl/tpm_dpll_core.sv
module tpm_dpll_core
    import tpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [PH_W-1:0]   fcw_i,
    input  logic [PH_W-1:0]   fmod_i,
    input  logic [INC_W-1:0]  osc_inc_i,
    input  logic [FRAC_W-1:0] tdc_frac_i,
    input  logic [SH_W-1:0]   pole_sh_i,
    input  logic [SH_W-1:0]   kp_sh_i,
    input  logic [SH_W-1:0]   ki_sh_i,
    input  logic [G_W-1:0]    gain_inv_i,
    output logic [PH_W-1:0]   tw_o,
    output logic              tw_vld_o
);
    phase_t  pe;
    phase_t  corr;
    phase_t  tw;
    lf_cfg_t cfg;

    always_comb begin
        cfg.pole_sh = pole_sh_i;
        cfg.kp_sh   = kp_sh_i;
        cfg.ki_sh   = ki_sh_i;
        tw_o        = tw;
    end

    tpm_phase_detect u_pd (
        .clk      (clk),
        .rst      (rst),
        .fcw      (phase_t'(fcw_i)),
        .fmod     (phase_t'(fmod_i)),
        .osc_inc  (osc_inc_i),
        .tdc_frac (tdc_frac_i),
        .pe       (pe)
    );

    tpm_loop_filter u_lf (
        .clk  (clk),
        .rst  (rst),
        .pe   (pe),
        .cfg  (cfg),
        .corr (corr)
    );

    tpm_dco_norm u_dco (
        .clk      (clk),
        .rst      (rst),
        .corr     (corr),
        .fmod     (phase_t'(fmod_i)),
        .gain_inv (gain_inv_i),
        .tw       (tw),
        .vld      (tw_vld_o)
    );
endmodule

// File: tb/tb_tpm_dpll_core.sv
`timescale 1ns/1ps
module tb_tpm_dpll_core;
    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [23:0]       fcw = '0;
    logic [23:0]       fmod = '0;
    logic [7:0]        inc = '0;
    logic [7:0]        tdc = '0;
    logic [3:0]        pole_sh = '0, kp_sh = 4'd2, ki_sh = 4'd6;
    logic [11:0]       gain = 12'd2048;
    logic [23:0]       tw;
    logic              vld;

    int n_chk = 0;
    int n_bad = 0;
    string req = "R1";

    logic signed [23:0] m_ref, m_smooth, m_int, m_lfp, m_tw;
    logic [15:0]        m_cnt;
    logic               m_vld;

    always #2.5 clk = ~clk;

    tpm_dpll_core dut (
        .clk(clk), .rst(rst), .fcw_i(fcw), .fmod_i(fmod), .osc_inc_i(inc),
        .tdc_frac_i(tdc), .pole_sh_i(pole_sh), .kp_sh_i(kp_sh), .ki_sh_i(ki_sh),
        .gain_inv_i(gain), .tw_o(tw), .tw_vld_o(vld)
    );

    task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        logic signed [23:0] pe, lf, s;
        logic signed [36:0] p;
        if (rst) begin
            m_ref = '0; m_smooth = '0; m_int = '0; m_lfp = '0; m_tw = '0;
            m_cnt = '0; m_vld = 1'b0;
        end else begin
            pe = m_ref - $signed({m_cnt, 8'h00}) + $signed({16'h0, tdc});
            lf = (m_smooth >>> kp_sh) + m_int;
            s  = lf - m_lfp + $signed(fmod);
            p  = s * $signed({1'b0, gain});
            m_tw     = p[34:11];
            m_lfp    = lf;
            m_int    = m_int + (m_smooth >>> ki_sh);
            m_smooth = m_smooth + ((pe - m_smooth) >>> pole_sh);
            m_ref    = m_ref + $signed(fcw) + $signed(fmod);
            m_cnt    = m_cnt + 16'(inc);
            m_vld    = 1'b1;
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        #1;
        check({req, " tw"}, tw, m_tw);
        check({req, " vld"}, {23'h0, vld}, {23'h0, m_vld});
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic t_reset();
        req = "R1";
        rst = 1'b1;
        steps(3);
        check("R1 tw cleared", tw, 24'h0);
        check("R1 vld low", {23'h0, vld}, 24'h0);
        rst = 1'b0;
        req = "R9";
        step();
        check("R9 vld rises", {23'h0, vld}, 24'h1);
    endtask

    task automatic t_locked();
        req = "R2";
        fcw = 24'h000400; inc = 8'd4; tdc = '0; fmod = '0;
        for (int i = 0; i < 20; i++) begin
            step();
            check("R7 locked tw zero", tw, 24'h0);
        end
    endtask

    task automatic t_mod_step();
        req = "R8";
        fmod = 24'h000020;
        step();
        check("R8 direct path first word", tw, 24'h000020);
        req = "R6";
        steps(40);
        fmod = 24'hFFFFC0;
        req = "R2";
        steps(40);
        fmod = '0;
        steps(20);
    endtask

    task automatic t_gain();
        req = "R8";
        gain = 12'd1024;
        fmod = 24'hFFFF00;
        step();
        gain = 12'd4095;
        fmod = 24'h000155;
        steps(30);
        gain = 12'd2048;
        fmod = '0;
        steps(10);
    endtask

    task automatic t_tdc();
        req = "R4";
        for (int i = 0; i < 24; i++) begin
            tdc = 8'((i * 37) & 8'hFF);
            step();
        end
        tdc = '0;
        steps(10);
    endtask

    task automatic t_pole();
        req = "R5";
        pole_sh = 4'd3; kp_sh = 4'd1; ki_sh = 4'd4;
        fmod = 24'h000080;
        steps(30);
        fmod = '0;
        pole_sh = 4'd0;
        req = "R6";
        steps(30);
    endtask

    task automatic t_wrap();
        req = "R1";
        rst = 1'b1;
        fcw = 24'h00FF00; inc = 8'd255; tdc = '0; fmod = '0;
        kp_sh = 4'd2; ki_sh = 4'd6;
        steps(2);
        rst = 1'b0;
        req = "R3";
        for (int i = 0; i < 270; i++) begin
            step();
            check("R3 counter wrap keeps lock", tw, 24'h0);
        end
    endtask

    task automatic t_reset_mid();
        req = "R3";
        fmod = 24'h000033;
        steps(15);
        req = "R1";
        rst = 1'b1;
        step();
        check("R1 mid-run clear", tw, 24'h0);
        rst = 1'b0;
        fmod = '0;
        fcw = 24'h000400; inc = 8'd4;
        req = "R9";
        step();
        check("R9 vld after release", {23'h0, vld}, 24'h1);
        steps(10);
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1;
        t_reset();
        t_locked();
        t_mod_step();
        t_gain();
        t_tdc();
        t_pole();
        t_wrap();
        t_reset_mid();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule